// File: doc/BRIEF.md
# Periodic Loaded Battery Test Scheduler

This block decides when a backup cell is put under load and keeps a sticky low-battery warning. A slow time-base tick drives every interval, so all durations are parameters counted in ticks. While supply power is valid, the block waits for an interval to run out and then raises a load-enable strobe for a fixed window. During that window only, a comparator flag tells it whether the loaded cell reads below its trip point. A failing reading asserts an active-low warning.

Once the warning is set, tests repeat at a short interval so that a fresh cell is noticed quickly. The warning clears only after a valid cell swap followed by a passing test. A valid swap means the presence input stayed low for a minimum number of ticks and then came back high. When power fails, all testing stops and every counter restarts. The warning is kept. After each power-up, one test is always run after a short recovery delay, whatever the warning state.

Top module: `batt_test_sched`

## Requirements
- R1: After reset, `load_en_o` is 0 and `warn_n_o` is 1 (warning inactive), whatever the other inputs are.
- R2: On the first clock with `pwr_ok_i` high after a period of it being low, or after reset, all counters restart. The first load window then opens on the `RECOV_TICKS`-th tick, and this happens whether or not the warning is active.
- R3: With the warning inactive, the next window opens on the `NORMAL_TICKS`-th tick after the previous window closed.
- R4: `load_en_o` rises only on a clock where `tick_i` is high and power is valid. It stays high for exactly `LOAD_TICKS` ticks and falls on the last of them, or on the clock after power loss.
- R5: If `below_trip_i` is high on any clock while the window is open, `warn_n_o` goes to 0 on the same clock edge at which `load_en_o` falls.
- R6: `below_trip_i` has no effect while no window is open.
- R7: With the warning active, the next window opens on the `WARN_TICKS`-th tick after the previous one closed.
- R8: An active warning clears only at the close of a window in which `below_trip_i` never went high. A valid replacement must also have happened since the previous window closed or since power-up. Otherwise the warning stays active.
- R9: While `pwr_ok_i` is 0, the load stays off from the next clock on and ticks are ignored. An open window is abandoned without changing the warning, and the warning state is held. Any replacement seen so far is forgotten.
- R10: A replacement is valid only if `batt_present_i` stays 0 for at least `DETACH_TICKS` consecutive ticks while power is valid, and `batt_present_i` is 1 at the close of the window. A shorter removal has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-clock time-base pulse; all intervals are counted in these |
| pwr_ok_i | input | 1 | Supply is within tolerance |
| below_trip_i | input | 1 | Loaded cell reads below trip point (used only during a window) |
| batt_present_i | input | 1 | A cell is attached |
| load_en_o | output | 1 | Test load enable, high during the window |
| warn_n_o | output | 1 | Active-low sticky battery warning |

## Verification
On every cycle, the assertions check several properties. The load may start only on a tick with power valid, and it may drop only on a tick or on power loss. It is off after any clock with power invalid. The warning may change only at the edge that closes a window, and it clears only with the cell present and the comparator passing on that clock. The exact interval lengths need the bench's scenarios to show them: the recovery, slow and fast intervals, and the window length. The same holds for the sticky retention across power loss, the rejection of a too-short removal, and the forced retest after power-up with the warning active.

// File: rtl/bts_pkg.sv
// Shared types and helpers for the battery test scheduler.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bts_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_LOAD = 2'd2
    } seq_state_t;

    // Larger of two integers, used to size counters.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bts_sequencer.sv
// Test sequencer: counts ticks between tests and across the load window.
// Picks the recovery, slow or fast interval. Latches any comparator
// failure seen during the window, and flags the close of each window.
// Assumes tick_i is a single-clock pulse and every interval is >= 1.
module bts_sequencer #(
    parameter int NORMAL_TICKS = 86400,
    parameter int WARN_TICKS   = 5,
    parameter int LOAD_TICKS   = 1,
    parameter int RECOV_TICKS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pwr_ok_i,
    input  logic below_trip_i,
    input  logic warn_i,
    output logic load_en_o,
    output logic done_o,
    output logic fail_o
);
    import bts_pkg::*;

    localparam int MAXT = max2(max2(NORMAL_TICKS, WARN_TICKS),
                               max2(LOAD_TICKS, RECOV_TICKS));
    localparam int CW   = $clog2(MAXT + 1);

    seq_state_t    state_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] target;
    logic          first_q;
    logic          fail_q;
    logic          win_last;
    logic          wait_last;

    // Interval length for the current wait phase.
    always_comb begin
        if (first_q)     target = CW'(RECOV_TICKS - 1);
        else if (warn_i) target = CW'(WARN_TICKS - 1);
        else             target = CW'(NORMAL_TICKS - 1);
    end

    // Last-tick detection for both phases.
    always_comb begin
        wait_last = (cnt_q == target);
        win_last  = (cnt_q == CW'(LOAD_TICKS - 1));
    end

    // State, tick counter, first-test marker and failure latch.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok_i) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            first_q <= 1'b1;
            fail_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_OFF: begin
                    state_q <= ST_WAIT;
                    cnt_q   <= '0;
                    first_q <= 1'b1;
                    fail_q  <= 1'b0;
                end
                ST_WAIT: begin
                    fail_q <= 1'b0;
                    if (tick_i) begin
                        if (wait_last) begin
                            state_q <= ST_LOAD;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    if (below_trip_i) fail_q <= 1'b1;
                    if (tick_i) begin
                        if (win_last) begin
                            state_q <= ST_WAIT;
                            cnt_q   <= '0;
                            first_q <= 1'b0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_OFF;
            endcase
        end
    end

    // Window strobe, window-close pulse and the verdict for that close.
    always_comb begin
        load_en_o = (state_q == ST_LOAD);
        done_o    = load_en_o && tick_i && win_last && pwr_ok_i;
        fail_o    = fail_q || below_trip_i;
    end

endmodule

// File: rtl/bts_detach_mon.sv
// Replacement monitor: decides whether the cell was removed for long
// enough to count as a swap. The decision is kept until the next window
// closes or power is lost.
// Assumes DETACH_TICKS >= 1 and that removal is timed with power valid.
module bts_detach_mon #(
    parameter int DETACH_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pwr_ok_i,
    input  logic present_i,
    input  logic clear_i,
    output logic replaced_o
);
    localparam int DW = $clog2(DETACH_TICKS + 1);

    logic [DW-1:0] cnt_q;
    logic          ok_q;

    // Count consecutive absent ticks and latch a long-enough removal.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok_i) begin
            cnt_q <= '0;
            ok_q  <= 1'b0;
        end else begin
            if (present_i) begin
                cnt_q <= '0;
            end else if (tick_i && !ok_q) begin
                if (cnt_q == DW'(DETACH_TICKS - 1)) ok_q <= 1'b1;
                else                                cnt_q <= cnt_q + 1'b1;
            end
            if (clear_i) begin
                ok_q  <= 1'b0;
                cnt_q <= '0;
            end
        end
    end

    // A swap counts only once a cell is back in place.
    assign replaced_o = ok_q && present_i;

endmodule

// File: rtl/bts_warn_flag.sv
// Sticky warning register. Updated only at the close of a window:
// set on a failing test, cleared on a passing test after a valid swap.
// Survives power loss; cleared only by reset or a qualifying test.
module bts_warn_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic fail_i,
    input  logic replaced_i,
    output logic warn_o
);
    // Verdict applied at each window close.
    always_ff @(posedge clk) begin
        if (!rst_n)      warn_o <= 1'b0;
        else if (done_i) warn_o <= fail_i || (warn_o && !replaced_i);
    end

endmodule

// File: rtl/batt_test_sched.sv
// Top of the periodic loaded battery test scheduler. Connects the
// sequencer, the replacement monitor and the warning register, and drives
// the warning as an active-low, open-drain-style level.
// Assumes tick_i is a one-clock pulse; all intervals are in ticks.
module batt_test_sched #(
    parameter int NORMAL_TICKS = 86400,
    parameter int WARN_TICKS   = 5,
    parameter int LOAD_TICKS   = 1,
    parameter int RECOV_TICKS  = 2,
    parameter int DETACH_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pwr_ok_i,
    input  logic below_trip_i,
    input  logic batt_present_i,
    output logic load_en_o,
    output logic warn_n_o
);
    logic done;
    logic fail;
    logic replaced;
    logic warn;

    bts_sequencer #(
        .NORMAL_TICKS (NORMAL_TICKS),
        .WARN_TICKS   (WARN_TICKS),
        .LOAD_TICKS   (LOAD_TICKS),
        .RECOV_TICKS  (RECOV_TICKS)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .pwr_ok_i     (pwr_ok_i),
        .below_trip_i (below_trip_i),
        .warn_i       (warn),
        .load_en_o    (load_en_o),
        .done_o       (done),
        .fail_o       (fail)
    );

    bts_detach_mon #(
        .DETACH_TICKS (DETACH_TICKS)
    ) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .pwr_ok_i   (pwr_ok_i),
        .present_i  (batt_present_i),
        .clear_i    (done),
        .replaced_o (replaced)
    );

    bts_warn_flag u_warn (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .fail_i     (fail),
        .replaced_i (replaced),
        .warn_o     (warn)
    );

    // Active-low warning level.
    assign warn_n_o = ~warn;

endmodule

// File: rtl/bts_checker.sv
// Port-level properties of the battery test scheduler, bound to the top.
module bts_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic pwr_ok_i,
    input logic below_trip_i,
    input logic batt_present_i,
    input logic load_en_o,
    input logic warn_n_o
);
    // R9: no load on the clock after power is invalid
    p_load_off_nopwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok_i |=> !load_en_o);

    // R4: window opens only on a tick with power valid
    p_load_rise_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_en_o) |-> ($past(tick_i) && $past(pwr_ok_i)));

    // R4: window closes only on a tick or on power loss
    p_load_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_en_o) |-> ($past(tick_i) || !$past(pwr_ok_i)));

    // R5: warning moves only as a window closes
    p_warn_edge_at_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(warn_n_o) |-> ($past(load_en_o) && !load_en_o));

    // R8: clearing needs a passing comparator at the close
    p_clear_needs_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_n_o) |-> !$past(below_trip_i));

    // R10: clearing needs a cell in place at the close
    p_clear_needs_cell_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_n_o) |-> $past(batt_present_i));

endmodule

bind batt_test_sched bts_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_i         (tick_i),
    .pwr_ok_i       (pwr_ok_i),
    .below_trip_i   (below_trip_i),
    .batt_present_i (batt_present_i),
    .load_en_o      (load_en_o),
    .warn_n_o       (warn_n_o)
);

// File: tb/batt_test_sched_tb_top.sv
`timescale 1ns/1ps
module batt_test_sched_tb_top;

    localparam int NV = 25;
    // Vector: {pwr, below, present, ticks[7:0], exp_load, exp_warn_n}
    localparam logic [12:0] VEC [NV] = '{
        {1'b1,1'b0,1'b1,8'd1 ,1'b0,1'b1},  // 0  R2 recovery count
        {1'b1,1'b0,1'b1,8'd1 ,1'b1,1'b1},  // 1  R2 first window
        {1'b1,1'b1,1'b1,8'd0 ,1'b1,1'b1},  // 2  R4 window held, fail seen
        {1'b1,1'b0,1'b1,8'd3 ,1'b0,1'b0},  // 3  R5 warning set at close
        {1'b1,1'b0,1'b1,8'd4 ,1'b0,1'b0},  // 4  R7 fast interval pending
        {1'b1,1'b0,1'b1,8'd1 ,1'b1,1'b0},  // 5  R7 fast window opens
        {1'b1,1'b0,1'b1,8'd3 ,1'b0,1'b0},  // 6  R8 pass w/o swap keeps
        {1'b1,1'b0,1'b0,8'd3 ,1'b0,1'b0},  // 7  R10 long removal
        {1'b1,1'b0,1'b1,8'd1 ,1'b0,1'b0},  // 8  R8 cell back
        {1'b1,1'b0,1'b1,8'd1 ,1'b1,1'b0},  // 9  R7 window opens
        {1'b1,1'b0,1'b1,8'd3 ,1'b0,1'b1},  // 10 R8 cleared
        {1'b1,1'b1,1'b1,8'd5 ,1'b0,1'b1},  // 11 R6 comparator ignored
        {1'b1,1'b0,1'b1,8'd14,1'b0,1'b1},  // 12 R3 slow interval pending
        {1'b1,1'b0,1'b1,8'd1 ,1'b1,1'b1},  // 13 R3 slow window opens
        {1'b0,1'b1,1'b1,8'd0 ,1'b0,1'b1},  // 14 R9 window abandoned
        {1'b0,1'b1,1'b1,8'd5 ,1'b0,1'b1},  // 15 R9 ticks ignored
        {1'b1,1'b0,1'b1,8'd2 ,1'b1,1'b1},  // 16 R2 forced test
        {1'b1,1'b1,1'b1,8'd3 ,1'b0,1'b0},  // 17 R5 warning set
        {1'b0,1'b0,1'b1,8'd2 ,1'b0,1'b0},  // 18 R9 warning held
        {1'b1,1'b0,1'b1,8'd2 ,1'b1,1'b0},  // 19 R2 retest with warning
        {1'b1,1'b0,1'b1,8'd3 ,1'b0,1'b0},  // 20 R8 no swap, stays
        {1'b1,1'b0,1'b0,8'd2 ,1'b0,1'b0},  // 21 R10 short removal
        {1'b1,1'b0,1'b1,8'd2 ,1'b0,1'b0},  // 22 R10 cell back early
        {1'b1,1'b0,1'b1,8'd1 ,1'b1,1'b0},  // 23 R7 window opens
        {1'b1,1'b0,1'b1,8'd3 ,1'b0,1'b0}   // 24 R10 short removal ignored
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic pwr_ok_i = 1'b0;
    logic below_trip_i = 1'b0;
    logic batt_present_i = 1'b1;
    logic load_en_o;
    logic warn_n_o;
    int   n_chk = 0;
    int   n_fail = 0;

    always #2.5 clk = ~clk;

    batt_test_sched #(
        .NORMAL_TICKS (20),
        .WARN_TICKS   (5),
        .LOAD_TICKS   (3),
        .RECOV_TICKS  (2),
        .DETACH_TICKS (3)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick_i),
        .pwr_ok_i       (pwr_ok_i),
        .below_trip_i   (below_trip_i),
        .batt_present_i (batt_present_i),
        .load_en_o      (load_en_o),
        .warn_n_o       (warn_n_o)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 16, 19:        return "R2";
            2:                   return "R4";
            3, 17:               return "R5";
            4, 5, 9, 23:         return "R7";
            6, 8, 10, 20:        return "R8";
            11:                  return "R6";
            12, 13:              return "R3";
            14, 15, 18:          return "R9";
            default:             return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic pulse_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic step(input logic pwr, input logic below,
                        input logic pres, input int n);
        pwr_ok_i       = pwr;
        below_trip_i   = below;
        batt_present_i = pres;
        @(negedge clk);
        pulse_ticks(n);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "load after reset", load_en_o, 1'b0);
        check("R1", "warn_n after reset", warn_n_o, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12], VEC[i][11], VEC[i][10], int'(VEC[i][9:2]));
            check(vec_tag(i), $sformatf("vec %0d load", i), load_en_o, VEC[i][1]);
            check(vec_tag(i), $sformatf("vec %0d warn_n", i), warn_n_o, VEC[i][0]);
        end

        // R1: reset in mid-run with warning active
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "load after mid reset", load_en_o, 1'b0);
        check("R1", "warn_n after mid reset", warn_n_o, 1'b1);
        rst_n = 1'b1;

        // R4: window length of LOAD_TICKS ticks
        step(1'b1, 1'b0, 1'b1, 2);
        check("R4", "window open", load_en_o, 1'b1);
        pulse_ticks(2);
        check("R4", "window still open", load_en_o, 1'b1);
        pulse_ticks(1);
        check("R4", "window closed", load_en_o, 1'b0);
        check("R4", "pass keeps warn off", warn_n_o, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule